// File: doc/BRIEF.md
# Single-Pin Edge-Spacing Debug Bit Codec

This block moves serial-wire debug bits over a single bidirectional pin. A bit is not carried by a level or by a clock. It is carried by the time between two consecutive edges on the line, and either polarity of edge counts. A short spacing (nominally 0.5 µs) stands for 0. A long spacing (nominally 1 µs) stands for 1. The same code is used in both directions. A sequence of N bits therefore takes N+1 edges: an opening edge, then one edge at the end of each bit's spacing.

The transmit side takes bits over a valid/ready handshake and toggles the line after the right number of system clock ticks. The receive side synchronises the pin, measures the ticks between edges, and splits short from long at a midpoint threshold, which leaves wide margin for clock mismatch between the two ends. A spacing longer than twice the long interval ends a sequence. A direction input selects the mode. On every change of mode the pin is released for one long interval before the new driver takes it.

All tick counts come from the system clock frequency parameter. At the default 125 MHz they are: short = 62, long = 125, threshold = 93, idle limit = 250.

Top module: `edge_gap_codec`

## Requirements
- R1: After reset the pin is released (pinOe=0), pinOut=0, txReady=0, rxValid=0 and rxEnd=0, and the block is in the receive direction.
- R2: In transmit direction, a bit accepted while no sequence is running produces an opening toggle of pinOut on the accepting clock edge. The next toggle follows 62 cycles later for a 0, or 125 cycles later for a 1.
- R3: If a bit is offered on the cycle a bit's spacing ends, it is accepted on that edge. The closing toggle of one bit is then the opening of the next, so a sequence of N bits gives exactly N+1 toggles with no gaps between them.
- R4: When a spacing ends with no bit offered, the sequence is closed. txReady stays low, and the next opening toggle comes more than 250 cycles after the last toggle.
- R5: In receive direction, pinIn goes through a two-flop synchroniser and both edge polarities are detected. Each edge that follows an earlier edge within 250 cycles yields a one-cycle rxValid. rxData is 0 if the spacing is below 93 cycles, and 1 if it is from 93 to 250 cycles.
- R6: The first edge after idle yields no bit. When 250 cycles pass after an edge with no new edge, rxEnd pulses for one cycle and the receiver forgets that edge. A spacing of 251 or more therefore yields no bit.
- R7: When dirTx changes, pinOe is low from the next clock edge for 125 cycles. When the new direction is transmit, pinOe rises exactly 126 cycles after the change.
- R8: While the block transmits or is turning around, edges on pinIn produce neither rxValid nor rxEnd.
- R9: pinOut changes only while pinOe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dirTx | input | 1 | Requested direction: 1 transmit, 0 receive |
| txData | input | 1 | Bit to send |
| txValid | input | 1 | txData is offered |
| txReady | output | 1 | A bit is taken on this clock edge if txValid is high |
| rxData | output | 1 | Decoded bit |
| rxValid | output | 1 | One-cycle strobe qualifying rxData |
| rxEnd | output | 1 | One-cycle strobe marking the end of a received sequence |
| pinIn | input | 1 | Sampled pin level |
| pinOut | output | 1 | Level driven onto the pin |
| pinOe | output | 1 | Pin output enable (tristate control) |

## Verification
A wrong internal state surfaces at the ports within one bit time. A gap counter that is off by one flips the decoded value only at spacings next to the threshold or the idle limit, so spacings of 92, 93, 250 and 251 cycles are driven on purpose. A mis-loaded transmit timer shows up as a toggle spacing that is wrong by at least one cycle on the next edge, at most 125 cycles later. A wrong turnaround count moves the rising edge of pinOe off its 126th cycle. A receiver that is not muted reports a spurious bit within about 65 cycles of a stray edge during transmit.

// File: rtl/edge_gap_pkg.sv
package edge_gap_pkg;

  typedef enum logic [1:0] {
    TX_OFF,
    TX_IDLE,
    TX_GAP,
    TX_HOLD
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic lineFlip;
    logic timerLoadBit;
    logic timerLoadHold;
    logic gapRestart;
    logic rxEmit;
    logic rxFlush;
  } ctrlStrobe_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic timerDone;
    logic edgeSeen;
    logic gapIdle;
  } dpStatus_t;

endpackage

// File: rtl/edge_gap_dp.sv
module edge_gap_dp
  import edge_gap_pkg::*;
#(
  parameter int SHORT_TICKS  = 62,
  parameter int LONG_TICKS   = 125,
  parameter int THRESH_TICKS = 93,
  parameter int IDLE_TICKS   = 250,
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        txBit,
  input  logic        pinIn,
  output dpStatus_t   status,
  output logic        lineLevel,
  output logic        rxBit,
  output logic        rxValid,
  output logic        rxEnd
);

  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_TICKS - 1);
  localparam logic [CNT_W-1:0] IDLE_CNT   = CNT_W'(IDLE_TICKS);
  localparam logic [CNT_W-1:0] THRESH_CNT = CNT_W'(THRESH_TICKS);

  // synchroniser chain plus one history stage for edge detection
  logic [SYNC_STAGES:0] syncQ;
  logic [CNT_W-1:0]     gapCnt;
  logic [CNT_W-1:0]     txTimer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], pinIn};
  end

  // ticks since the last synchronised edge, saturating at the idle limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   gapCnt <= IDLE_CNT;
    else if (strobe.gapRestart)  gapCnt <= CNT_W'(1);
    else if (gapCnt != IDLE_CNT) gapCnt <= gapCnt + CNT_W'(1);
  end

  // decoded bit and strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBit   <= 1'b0;
      rxValid <= 1'b0;
      rxEnd   <= 1'b0;
    end else begin
      rxValid <= strobe.rxEmit;
      rxEnd   <= strobe.rxFlush;
      if (strobe.rxEmit) rxBit <= (gapCnt >= THRESH_CNT);
    end
  end

  // transmit interval timer, also used for the post-sequence hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     txTimer <= '0;
    else if (strobe.timerLoadBit)  txTimer <= txBit ? LONG_LOAD : SHORT_LOAD;
    else if (strobe.timerLoadHold) txTimer <= IDLE_CNT;
    else if (txTimer != '0)        txTimer <= txTimer - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lineLevel <= 1'b0;
    else if (strobe.lineFlip) lineLevel <= ~lineLevel;
  end

  always_comb begin
    status.timerDone = (txTimer == '0);
    status.edgeSeen  = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];
    status.gapIdle   = (gapCnt == IDLE_CNT);
  end

endmodule

// File: rtl/edge_gap_ctrl.sv
module edge_gap_ctrl
  import edge_gap_pkg::*;
#(
  parameter int LONG_TICKS = 125,
  parameter int CNT_W      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dirTx,
  input  logic        txValid,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        txReady,
  output logic        pinOe
);

  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(LONG_TICKS - 1);

  logic             modeTx;
  logic             turning;
  logic [CNT_W-1:0] turnCnt;
  logic             haveEdge;
  txState_t         txState;

  logic txEn;
  logic rxEn;
  logic gapEnds;
  logic accept;

  // direction change: release the pin for one long interval, then settle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeTx  <= 1'b0;
      turning <= 1'b0;
      turnCnt <= '0;
    end else if (turning) begin
      if (turnCnt == '0) begin
        turning <= 1'b0;
        modeTx  <= dirTx;
      end else begin
        turnCnt <= turnCnt - CNT_W'(1);
      end
    end else if (dirTx != modeTx) begin
      turning <= 1'b1;
      turnCnt <= TURN_LOAD;
    end
  end

  always_comb begin
    txEn    = modeTx & ~turning;
    rxEn    = ~modeTx & ~turning;
    gapEnds = txEn & (txState == TX_GAP) & status.timerDone;
    txReady = txEn & ((txState == TX_IDLE) | gapEnds);
    accept  = txReady & txValid;

    strobe               = '0;
    strobe.lineFlip      = (txEn & (txState == TX_IDLE) & accept) | gapEnds;
    strobe.timerLoadBit  = accept;
    strobe.timerLoadHold = gapEnds & ~txValid;
    strobe.gapRestart    = status.edgeSeen;
    strobe.rxEmit        = rxEn & haveEdge & status.edgeSeen;
    strobe.rxFlush       = rxEn & haveEdge & ~status.edgeSeen & status.gapIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_OFF;
    end else if (!txEn) begin
      txState <= TX_OFF;
    end else begin
      unique case (txState)
        TX_OFF:  txState <= TX_IDLE;
        TX_IDLE: if (accept) txState <= TX_GAP;
        TX_GAP:  if (gapEnds && !txValid) txState <= TX_HOLD;
        TX_HOLD: if (status.timerDone) txState <= TX_IDLE;
        default: txState <= TX_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                haveEdge <= 1'b0;
    else if (!rxEn)           haveEdge <= 1'b0;
    else if (status.edgeSeen) haveEdge <= 1'b1;
    else if (strobe.rxFlush)  haveEdge <= 1'b0;
  end

  assign pinOe = txEn;

endmodule

// File: rtl/edge_gap_codec.sv
module edge_gap_codec
  import edge_gap_pkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int SHORT_NS = 500,
  parameter int LONG_NS  = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic dirTx,
  input  logic txData,
  input  logic txValid,
  output logic txReady,
  output logic rxData,
  output logic rxValid,
  output logic rxEnd,
  input  logic pinIn,
  output logic pinOut,
  output logic pinOe
);

  localparam int KHZ          = CLK_HZ / 1000;
  localparam int SHORT_TICKS  = KHZ * SHORT_NS / 1_000_000;
  localparam int LONG_TICKS   = KHZ * LONG_NS / 1_000_000;
  localparam int THRESH_TICKS = KHZ * ((SHORT_NS + LONG_NS) / 2) / 1_000_000;
  localparam int IDLE_TICKS   = 2 * LONG_TICKS;
  localparam int CNT_W        = $clog2(IDLE_TICKS + 1);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  edge_gap_ctrl #(
    .LONG_TICKS (LONG_TICKS),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .dirTx   (dirTx),
    .txValid (txValid),
    .status  (status),
    .strobe  (strobe),
    .txReady (txReady),
    .pinOe   (pinOe)
  );

  edge_gap_dp #(
    .SHORT_TICKS  (SHORT_TICKS),
    .LONG_TICKS   (LONG_TICKS),
    .THRESH_TICKS (THRESH_TICKS),
    .IDLE_TICKS   (IDLE_TICKS),
    .SYNC_STAGES  (2),
    .CNT_W        (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .txBit     (txData),
    .pinIn     (pinIn),
    .status    (status),
    .lineLevel (pinOut),
    .rxBit     (rxData),
    .rxValid   (rxValid),
    .rxEnd     (rxEnd)
  );

endmodule

// File: rtl/edge_gap_codec_chk.sv
module edge_gap_codec_chk (
  input logic clk,
  input logic rstN,
  input logic dirTx,
  input logic txValid,
  input logic txReady,
  input logic rxValid,
  input logic rxEnd,
  input logic pinOut,
  input logic pinOe
);

  // R9
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut != $past(pinOut)) |-> $past(pinOe));

  // R2
  accept_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (pinOut != $past(pinOut)));

  // R2
  ready_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> pinOe);

  // R8
  rx_mute_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinOe |-> (!rxValid && !rxEnd));

  // R6
  one_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && rxEnd));

  // R7
  turn_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinOe) |-> $past(dirTx));

endmodule

bind edge_gap_codec edge_gap_codec_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .dirTx   (dirTx),
  .txValid (txValid),
  .txReady (txReady),
  .rxValid (rxValid),
  .rxEnd   (rxEnd),
  .pinOut  (pinOut),
  .pinOe   (pinOe)
);

// File: tb/edge_gap_codec_bench.sv
module edge_gap_codec_bench;

  localparam int SHORT_T = 62;
  localparam int LONG_T  = 125;
  localparam int IDLE_T  = 250;
  localparam int NVEC    = 8;

  // receive vectors: spacing in cycles and the bit it must decode to (R5)
  localparam int RX_GAP[NVEC] = '{62, 125, 92, 93, 30, 250, 200, 70};
  localparam bit RX_EXP[NVEC] = '{0,  1,   0,  1,  0,  1,   1,   0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirTx = 1'b0;
  logic txData = 1'b0;
  logic txValid = 1'b0;
  logic pinIn = 1'b0;
  logic txReady, rxData, rxValid, rxEnd, pinOut, pinOe;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int capN = 0;
  int endN = 0;
  int togN = 0;
  logic capBits [64];
  int   togT [64];
  logic lastOut = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  edge_gap_codec u_edge_gap_codec (
    .clk     (clk),
    .rstN    (rstN),
    .dirTx   (dirTx),
    .txData  (txData),
    .txValid (txValid),
    .txReady (txReady),
    .rxData  (rxData),
    .rxValid (rxValid),
    .rxEnd   (rxEnd),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );

  // monitors sample between edges
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN && rxValid && capN < 64) begin
      capBits[capN] = rxData;
      capN = capN + 1;
    end
    if (rstN && rxEnd) endN = endN + 1;
    if (pinOut !== lastOut && togN < 64) begin
      togT[togN] = cyc;
      togN = togN + 1;
    end
    lastOut = pinOut;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      txData  = bits[i];
      txValid = 1'b1;
      while (!txReady) @(negedge clk);
      @(negedge clk);
    end
    txValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0, e0, t0, n0;
    logic [15:0] txPat;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pinOe == 1'b0,   "R1 pinOe",   pinOe,   0);
    check(pinOut == 1'b0,  "R1 pinOut",  pinOut,  0);
    check(txReady == 1'b0, "R1 txReady", txReady, 0);
    check(rxValid == 1'b0 && rxEnd == 1'b0, "R1 rx strobes", rxValid | rxEnd, 0);

    // R5 table walk: opening edge, then one edge per vector
    c0 = capN; e0 = endN;
    pinIn = ~pinIn;
    for (int i = 0; i < NVEC; i++) begin
      repeat (RX_GAP[i]) @(negedge clk);
      pinIn = ~pinIn;
    end
    repeat (300) @(negedge clk);
    check(capN - c0 == NVEC, "R5 bit count", capN - c0, NVEC);
    for (int i = 0; i < NVEC; i++)
      check(capBits[c0 + i] == RX_EXP[i], $sformatf("R5 gap %0d", RX_GAP[i]),
            capBits[c0 + i], RX_EXP[i]);
    check(endN - e0 == 1, "R6 end after table", endN - e0, 1);

    // R6 spacing beyond the idle limit yields no bit and starts afresh
    c0 = capN; e0 = endN;
    pinIn = ~pinIn;
    repeat (IDLE_T + 1) @(negedge clk);
    pinIn = ~pinIn;
    repeat (SHORT_T) @(negedge clk);
    pinIn = ~pinIn;
    repeat (300) @(negedge clk);
    check(capN - c0 == 1, "R6 long gap bit count", capN - c0, 1);
    check(capBits[c0] == 1'b0, "R6 bit after restart", capBits[c0], 0);
    check(endN - e0 == 2, "R6 end count", endN - e0, 2);

    // R7 turnaround receive -> transmit
    dirTx = 1'b1;
    @(negedge clk);
    check(pinOe == 1'b0, "R7 released after change", pinOe, 0);
    repeat (LONG_T - 1) @(negedge clk);
    check(pinOe == 1'b0, "R7 still released at 125", pinOe, 0);
    @(negedge clk);
    check(pinOe == 1'b1, "R7 driven at 126", pinOe, 1);

    // R8 pin edges ignored while transmitting
    c0 = capN; e0 = endN;
    repeat (4) begin
      repeat (SHORT_T) @(negedge clk);
      pinIn = ~pinIn;
    end
    repeat (300) @(negedge clk);
    check(capN == c0 && endN == e0, "R8 rx muted", capN - c0 + endN - e0, 0);

    // R2/R3 transmit a back-to-back sequence 1,0,0,1,1,0
    t0 = togN;
    txPat = 16'b0000_0000_0001_1001;
    sendBits(txPat, 6);
    wait (togN >= t0 + 7);
    @(negedge clk);
    check(togN - t0 == 7, "R3 toggle count", togN - t0, 7);
    for (int i = 0; i < 6; i++) begin
      int expGap;
      expGap = txPat[i] ? LONG_T : SHORT_T;
      check(togT[t0 + i + 1] - togT[t0 + i] == expGap, $sformatf("R2 tx spacing bit %0d", i),
            togT[t0 + i + 1] - togT[t0 + i], expGap);
    end

    // R4 a new sequence waits out the idle hold
    sendBits(16'h0001, 1);
    wait (togN >= t0 + 9);
    @(negedge clk);
    check(togT[t0 + 7] - togT[t0 + 6] > IDLE_T, "R4 hold before reopen",
          togT[t0 + 7] - togT[t0 + 6], IDLE_T + 1);
    check(togT[t0 + 8] - togT[t0 + 7] == LONG_T, "R2 single bit spacing",
          togT[t0 + 8] - togT[t0 + 7], LONG_T);
    repeat (IDLE_T + 5) @(negedge clk);

    // R7 turnaround transmit -> receive, then reception resumes
    dirTx = 1'b0;
    @(negedge clk);
    check(pinOe == 1'b0, "R7 released on leaving transmit", pinOe, 0);
    repeat (LONG_T + 5) @(negedge clk);
    c0 = capN;
    n0 = 0;
    pinIn = ~pinIn;
    repeat (LONG_T) @(negedge clk);
    pinIn = ~pinIn;
    repeat (10) @(negedge clk);
    if (capN > c0) n0 = capBits[c0];
    check(capN - c0 == 1 && n0 == 1, "R5 receive after turnaround", n0, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule